// File: doc/BRIEF.md
# Configuration Address Decode Router

This block sits on the host side of a port-based configuration mechanism. It holds the 32-bit configuration address word that software loads through the I/O port at 0CF8h. When software later touches the data window at 0CFCh–0CFFh, the block classifies the pending configuration access and presents the request-header byte fields that the rest of the host bridge needs to build the cycle.

An access is routed to one of four destinations. It can go to an on-chip device, become a Type 0 cycle on the local bus, become a Type 1 cycle for a remote bus, or be forwarded to the downstream bridge whose bus window is given by the `sec_bus`/`sub_bus` inputs. Byte and word accesses to the address port do not touch the word. They are flagged so that they travel on as plain I/O. Moving the data, the bridge's own registers and assembling packets are handled elsewhere.

Every output is registered. A result appears on the clock edge that follows the access that caused it and is held for one cycle.

Top module: `cfg_addr_router`

## Requirements
- R1: After reset the address word reads 00000000h, and `io_rdata_vld`, `io_pass` and `route_valid` are all 0.
- R2: A write to 0CF8h with `io_be`=4'hF and `io_addr[1:0]`=0 loads bit 31 and bits 23:2 from `io_wdata`. A read with the same conditions raises `io_rdata_vld` one cycle later, with the stored word on `io_rdata`.
- R3: Bits 30:24 and 1:0 of the address word always read as zero, whatever value was written.
- R4: An access that hits the 0CF8h doubleword with a nonzero byte enable but is not a full aligned access leaves the word unchanged, raises `io_pass` one cycle later and does not raise `io_rdata_vld`.
- R5: A data-window access (0CFCh–0CFFh) while bit 31 of the word is 0 never raises `route_valid`.
- R6: With bit 31 set, bus 0 and device 0, 1, 2 or 7, the route is internal (`route_kind`=0).
- R7: With bit 31 set, bus 0 and any other device number, the route is Type 0 (`route_kind`=1).
- R8: With bit 31 set and a nonzero bus below `sec_bus` or above `sub_bus`, the route is Type 1 (`route_kind`=2).
- R9: With bit 31 set and a nonzero bus from `sec_bus` through `sub_bus` inclusive, the route is forward (`route_kind`=3).
- R10: `route_drop` is 1 exactly when the route is internal and the function number is neither 0 nor 1. The data side then returns all ones on reads and discards writes.
- R11: While `route_valid` is 1, the outputs carry the following: `hdr_bus` holds word bits 23:16. `hdr_devfn` holds the device in [7:3] and the function in [2:0]. `hdr_reg` holds the register number in [7:2] with zeros in [1:0]. `route_write` repeats the direction of the window access.
- R12: `route_valid` rises exactly in the cycle after a data-window access made with bit 31 set, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| sec_bus | input | 8 | Lowest bus number behind the downstream bridge |
| sub_bus | input | 8 | Highest bus number behind the downstream bridge |
| io_rdata_vld | output | 1 | Read of the address word completed |
| io_rdata | output | 32 | Address word read data |
| io_pass | output | 1 | Narrow access to the address port, passed on as plain I/O |
| route_valid | output | 1 | Classification result valid |
| route_kind | output | 2 | 0 internal, 1 Type 0, 2 Type 1, 3 forward |
| route_drop | output | 1 | Internal access to an unsupported function |
| route_write | output | 1 | Direction of the classified access |
| hdr_bus | output | 8 | Header bus byte |
| hdr_devfn | output | 8 | Header device/function byte |
| hdr_reg | output | 8 | Header register byte |

## Verification
The bench builds the block with its default parameters: ports 0CF8h and 0CFCh, internal devices 0, 1, 2 and 7, and functions 0 and 1 accepted. It draws bus numbers from a small pool that includes 0 and values near the two window edges, and it moves `sec_bus`/`sub_bus` between accesses. This makes every route kind occur often, including the inclusive window boundaries. It also sends full, misaligned and partial byte enables to the address port, so both the load path and the pass-through path are exercised.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    typedef enum logic [1:0] {
        RT_INTERNAL = 2'd0,
        RT_TYPE0    = 2'd1,
        RT_TYPE1    = 2'd2,
        RT_FORWARD  = 2'd3
    } route_kind_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regno;
    } cfg_fields_t;

    localparam logic [31:0] CFG_WMASK = 32'h80FF_FFFC;

    function automatic cfg_fields_t cfg_unpack(input logic [31:0] w);
        cfg_fields_t f;
        f.en    = w[31];
        f.bus   = w[23:16];
        f.dev   = w[15:11];
        f.fn    = w[10:8];
        f.regno = w[7:2];
        return f;
    endfunction

    function automatic logic [31:0] cfg_pack(input cfg_fields_t f);
        return {f.en, 7'd0, f.bus, f.dev, f.fn, f.regno, 2'b00};
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   CFG_PORT  = 16'h0CF8,
    parameter logic [AW-1:0]   DATA_PORT = 16'h0CFC
) (
    input  logic          io_valid,
    input  logic          io_write,
    input  logic [AW-1:0] io_addr,
    input  logic [3:0]    io_be,
    output logic          full_wr,
    output logic          full_rd,
    output logic          narrow,
    output logic          win_hit
);
    logic cfg_word_hit;
    logic full_shape;

    always_comb begin
        cfg_word_hit = io_valid && (io_addr[AW-1:2] == CFG_PORT[AW-1:2]);
        full_shape   = (io_be == 4'hF) && (io_addr[1:0] == 2'b00);
        full_wr      = cfg_word_hit && full_shape && io_write;
        full_rd      = cfg_word_hit && full_shape && !io_write;
        narrow       = cfg_word_hit && !full_shape && (io_be != 4'h0);
        win_hit      = io_valid && (io_addr[AW-1:2] == DATA_PORT[AW-1:2]);
    end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output cfg_fields_t fields_q
);
    cfg_fields_t fields_d;

    always_comb begin
        fields_d = fields_q;
        if (wr_en) begin
            fields_d = cfg_unpack(wdata & CFG_WMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else begin
            fields_q <= fields_d;
        end
    end
endmodule

// File: rtl/cfg_route_classify.sv
module cfg_route_classify
    import cfg_route_pkg::*;
#(
    parameter logic [31:0] INT_DEV_MASK = 32'h0000_0087,
    parameter logic [7:0]  FUNC_OK_MASK = 8'h03
) (
    input  cfg_fields_t fields,
    input  logic [7:0]  sec_bus,
    input  logic [7:0]  sub_bus,
    output route_kind_e kind,
    output logic        drop
);
    logic bus_zero;
    logic dev_local;
    logic fn_ok;
    logic in_window;

    always_comb begin
        bus_zero  = (fields.bus == 8'd0);
        dev_local = INT_DEV_MASK[fields.dev];
        fn_ok     = FUNC_OK_MASK[fields.fn];
        in_window = (fields.bus >= sec_bus) && (fields.bus <= sub_bus);
        drop      = 1'b0;
        if (bus_zero) begin
            if (dev_local) begin
                kind = RT_INTERNAL;
                drop = !fn_ok;
            end else begin
                kind = RT_TYPE0;
            end
        end else if (in_window) begin
            kind = RT_FORWARD;
        end else begin
            kind = RT_TYPE1;
        end
    end
endmodule

// File: rtl/cfg_addr_router.sv
module cfg_addr_router
    import cfg_route_pkg::*;
#(
    parameter int              AW           = 16,
    parameter logic [AW-1:0]   CFG_PORT     = 16'h0CF8,
    parameter logic [AW-1:0]   DATA_PORT    = 16'h0CFC,
    parameter logic [31:0]     INT_DEV_MASK = 32'h0000_0087,
    parameter logic [7:0]      FUNC_OK_MASK = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_valid,
    input  logic          io_write,
    input  logic [AW-1:0] io_addr,
    input  logic [3:0]    io_be,
    input  logic [31:0]   io_wdata,
    input  logic [7:0]    sec_bus,
    input  logic [7:0]    sub_bus,
    output logic          io_rdata_vld,
    output logic [31:0]   io_rdata,
    output logic          io_pass,
    output logic          route_valid,
    output logic [1:0]    route_kind,
    output logic          route_drop,
    output logic          route_write,
    output logic [7:0]    hdr_bus,
    output logic [7:0]    hdr_devfn,
    output logic [7:0]    hdr_reg
);
    typedef struct packed {
        logic        rd_vld;
        logic [31:0] rd_data;
        logic        pass;
        logic        rt_vld;
        route_kind_e kind;
        logic        drop;
        logic        wr;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [7:0]  regb;
    } out_t;

    logic        full_wr, full_rd, narrow, win_hit;
    cfg_fields_t fields_q;
    logic [31:0] cfg_word;
    route_kind_e cls_kind;
    logic        cls_drop;
    out_t        out_d, out_q;

    cfg_port_decode #(
        .AW        (AW),
        .CFG_PORT  (CFG_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .io_valid (io_valid),
        .io_write (io_write),
        .io_addr  (io_addr),
        .io_be    (io_be),
        .full_wr  (full_wr),
        .full_rd  (full_rd),
        .narrow   (narrow),
        .win_hit  (win_hit)
    );

    cfg_addr_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (full_wr),
        .wdata    (io_wdata),
        .fields_q (fields_q)
    );

    cfg_route_classify #(
        .INT_DEV_MASK (INT_DEV_MASK),
        .FUNC_OK_MASK (FUNC_OK_MASK)
    ) u_classify (
        .fields  (fields_q),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .kind    (cls_kind),
        .drop    (cls_drop)
    );

    assign cfg_word = cfg_pack(fields_q);

    always_comb begin
        out_d        = '0;
        out_d.rd_vld = full_rd;
        out_d.pass   = narrow;
        if (full_rd) begin
            out_d.rd_data = cfg_word;
        end
        if (win_hit && fields_q.en) begin
            out_d.rt_vld = 1'b1;
            out_d.kind   = cls_kind;
            out_d.drop   = cls_drop;
            out_d.wr     = io_write;
            out_d.bus    = fields_q.bus;
            out_d.devfn  = {fields_q.dev, fields_q.fn};
            out_d.regb   = {fields_q.regno, 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign io_rdata_vld = out_q.rd_vld;
    assign io_rdata     = out_q.rd_data;
    assign io_pass      = out_q.pass;
    assign route_valid  = out_q.rt_vld;
    assign route_kind   = out_q.kind;
    assign route_drop   = out_q.drop;
    assign route_write  = out_q.wr;
    assign hdr_bus      = out_q.bus;
    assign hdr_devfn    = out_q.devfn;
    assign hdr_reg      = out_q.regb;
endmodule

// File: rtl/cfg_addr_router_chk.sv
module cfg_addr_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_valid,
    input logic        io_write,
    input logic [15:0] io_addr,
    input logic [3:0]  io_be,
    input logic [31:0] cfg_word,
    input logic        io_rdata_vld,
    input logic [31:0] io_rdata,
    input logic        io_pass,
    input logic        route_valid,
    input logic [1:0]  route_kind,
    input logic        route_drop,
    input logic [7:0]  hdr_bus
);
    logic port_word;
    logic win_acc;
    assign port_word = io_valid && (io_addr[15:2] == 14'h033E);
    assign win_acc   = io_valid && (io_addr[15:2] == 14'h033F);

    // R4
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_word && io_write && !(io_be == 4'hF && io_addr[1:0] == 2'b00))
        |=> $stable(cfg_word));

    // R4
    pass_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_pass |-> !io_rdata_vld);

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_vld |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'b00));

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $past(cfg_word[31]));

    // R12
    route_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $past(win_acc));

    // R6
    bus0_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && hdr_bus == 8'd0) |-> (route_kind == 2'd0 || route_kind == 2'd1));

    // R10
    drop_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_drop |-> (route_valid && route_kind == 2'd0));
endmodule

bind cfg_addr_router cfg_addr_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_valid     (io_valid),
    .io_write     (io_write),
    .io_addr      (io_addr),
    .io_be        (io_be),
    .cfg_word     (cfg_word),
    .io_rdata_vld (io_rdata_vld),
    .io_rdata     (io_rdata),
    .io_pass      (io_pass),
    .route_valid  (route_valid),
    .route_kind   (route_kind),
    .route_drop   (route_drop),
    .hdr_bus      (hdr_bus)
);

// File: tb/tb_cfg_addr_router.sv
module tb_cfg_addr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [7:0]  sec_bus = 8'd4;
    logic [7:0]  sub_bus = 8'd9;
    logic        io_rdata_vld, io_pass, route_valid, route_drop, route_write;
    logic [31:0] io_rdata;
    logic [1:0]  route_kind;
    logic [7:0]  hdr_bus, hdr_devfn, hdr_reg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_reg = '0;

    always #5 clk = ~clk;

    cfg_addr_router dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_kind(logic [7:0] b, logic [4:0] d, logic [7:0] s, logic [7:0] u);
        if (b == 8'd0) return (d == 0 || d == 1 || d == 2 || d == 7) ? 2'd0 : 2'd1;
        return (b >= s && b <= u) ? 2'd3 : 2'd2;
    endfunction

    function automatic logic exp_drop(logic [31:0] w, logic [7:0] s, logic [7:0] u);
        return exp_kind(w[23:16], w[15:11], s, u) == 2'd0 && w[10:8] > 3'd1;
    endfunction

    task automatic access(input bit w, input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        bit port, full, win;
        logic [1:0] k;
        io_valid = 1'b1; io_write = w; io_addr = a; io_be = be; io_wdata = d;
        @(negedge clk);
        io_valid = 1'b0;
        port = (a[15:2] == 14'h033E);
        full = port && be == 4'hF && a[1:0] == 2'b00;
        win  = (a[15:2] == 14'h033F);
        chk(io_rdata_vld == (full && !w), "R2 rdata_vld", {31'd0, io_rdata_vld}, {31'd0, full && !w});
        if (full && !w) begin
            chk(io_rdata == m_reg, "R2 readback", io_rdata, m_reg);
            chk(io_rdata[30:24] == 0 && io_rdata[1:0] == 0, "R3 reserved", io_rdata, m_reg);
        end
        chk(io_pass == (port && !full && be != 0), "R4 pass", {31'd0, io_pass}, {31'd0, port && !full && be != 0});
        chk(route_valid == (win && m_reg[31]), "R5/R12 route_valid", {31'd0, route_valid}, {31'd0, win && m_reg[31]});
        if (win && m_reg[31]) begin
            k = exp_kind(m_reg[23:16], m_reg[15:11], sec_bus, sub_bus);
            chk(route_kind == k, k == 0 ? "R6 kind" : k == 1 ? "R7 kind" : k == 2 ? "R8 kind" : "R9 kind",
                {30'd0, route_kind}, {30'd0, k});
            chk(route_drop == exp_drop(m_reg, sec_bus, sub_bus), "R10 drop",
                {31'd0, route_drop}, {31'd0, exp_drop(m_reg, sec_bus, sub_bus)});
            chk({hdr_bus, hdr_devfn, hdr_reg, 7'd0, route_write} ==
                {m_reg[23:16], m_reg[15:8], m_reg[7:2], 2'b00, 7'd0, w}, "R11 header",
                {hdr_bus, hdr_devfn, hdr_reg, 7'd0, route_write},
                {m_reg[23:16], m_reg[15:8], m_reg[7:2], 2'b00, 7'd0, w});
        end
        if (full && w) m_reg = d & 32'h80FF_FFFC;
    endtask

    function automatic logic [31:0] mk_word(bit en, logic [7:0] b, logic [4:0] dv, logic [2:0] f, logic [5:0] r);
        return {en, 7'h7F, b, dv, f, r, 2'b11};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [8];
        void'($urandom(32'd2024));
        pool = '{8'd0, 8'd0, 8'd3, 8'd4, 8'd6, 8'd9, 8'd10, 8'd200};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!io_rdata_vld && !io_pass && !route_valid, "R1 reset outputs",
            {29'd0, io_rdata_vld, io_pass, route_valid}, 32'd0);
        rst_n = 1'b1;
        access(1'b0, 16'h0CF8, 4'hF, 32'd0);
        // R5 window with enable clear
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        // R2/R3 all ones
        access(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
        access(1'b0, 16'h0CF8, 4'hF, 32'd0);
        // R4 narrow and misaligned writes
        access(1'b1, 16'h0CF8, 4'h3, 32'h0);
        access(1'b1, 16'h0CFA, 4'hF, 32'h0);
        access(1'b0, 16'h0CF8, 4'hF, 32'd0);
        // R6 R7 R10 directed
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd0, 5'd7, 3'd1, 6'd5));
        access(1'b0, 16'h0CFE, 4'h4, 32'd0);
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd0, 5'd2, 3'd4, 6'd9));
        access(1'b1, 16'h0CFC, 4'hF, 32'd0);
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd0, 5'd3, 3'd6, 6'd63));
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        // R9/R8 inclusive window edges
        sec_bus = 8'd4; sub_bus = 8'd9;
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd4, 5'd0, 3'd0, 6'd1));
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd9, 5'd1, 3'd0, 6'd1));
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd10, 5'd1, 3'd0, 6'd1));
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        access(1'b1, 16'h0CF8, 4'hF, mk_word(1, 8'd3, 5'd1, 3'd0, 6'd1));
        access(1'b0, 16'h0CFC, 4'hF, 32'd0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [15:0] a;
            logic [3:0]  be;
            sel = $urandom_range(0, 9);
            if ($urandom_range(0, 7) == 0) begin
                sec_bus = pool[$urandom_range(2, 7)];
                sub_bus = sec_bus + 8'($urandom_range(0, 5));
            end
            be = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
            if (sel < 3) begin
                a = 16'h0CF8 + 16'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0);
                access(1'b1, a, be, mk_word(1'($urandom_range(0, 3) != 0), pool[$urandom_range(0, 7)],
                       5'($urandom_range(0, 9)), 3'($urandom), 6'($urandom)) ^ {1'b0, 7'($urandom), 24'd0});
            end else if (sel < 4) begin
                access(1'b0, 16'h0CF8, be, 32'd0);
            end else if (sel < 9) begin
                access(1'($urandom), 16'h0CFC + 16'($urandom_range(0, 3)), be, $urandom);
            end else begin
                access(1'($urandom), 16'h0080, be, $urandom);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule